// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps addresses issued by a bus master in a 32-bit address space onto a 40-bit downstream fabric address. Six programmable windows are provided. Each has a start address, a length counted in 4 KiB pages, and a downstream base held as a page number with a flag bit in the low nibble. A 32-bit register port programs the windows and an interrupt enable, and reads them back.

Each accepted request is compared against all windows in the same cycle. One cycle later the block returns either the translated address with the index of the window that matched, or a decode-error response. A decode error sets a sticky status bit that software clears by writing one to it. The interrupt line is that status bit gated by its enable bit. Window 0 is meant for extended configuration space. Windows 1, 2 and 3 are meant for downstream I/O, prefetchable memory and non-prefetchable memory. Windows 4 and 5 are spare. The hardware treats all six windows alike.

Top module: `ob_window_xlate`

## Requirements
- R1: After reset every window register, the interrupt-enable register and the status register read zero, `rspValid` and `irq` are low, and `reqReady` is high.
- R2: Register map, one 32-bit word per offset:
  - window i length at 0x00+4i, start at 0x18+4i, downstream base at 0x30+4i, for i from 0 to 5;
  - interrupt enable at 0xC8 and status at 0xCC;
  - a mapped offset reads back the last value written to it;
  - every other offset, including a misaligned one, reads zero and ignores writes.
- R3: Window i matches address A when its length L is non-zero and start <= A < start + L*4096. A window of length zero never matches.
- R4: On a hit the downstream address is {base[31:4], 12'h000} + (A - start), 40 bits wide.
- R5: When several windows match, the lowest-numbered window is used.
- R6: A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. Exactly one clock later `rspValid` is high for one cycle with `rspHit`, `rspWin` and `rspAddr`. No response appears without an accepted request.
- R7: If no window matches, the response has `rspDecErr`=1, `rspHit`=0, `rspWin`=0 and `rspAddr`=0. Status bit 6 (offset 0xCC) is set on the same edge.
- R8: Status bit 6 stays set until a register write to 0xCC with data bit 6 equal to 1. Writing 0 in bit 6 leaves it set.
- R9: `irq` is high exactly when status bit 6 and bit 6 of the interrupt-enable register (0xC8) are both 1.
- R10: `reqReady` is low in any cycle where `regWrEn` is high, so no request is accepted during a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| reqValid | input | 1 | Translation request valid |
| reqAddr | input | 32 | Address to translate |
| reqReady | output | 1 | Block can accept a request this cycle |
| rspValid | output | 1 | Response valid, one cycle after acceptance |
| rspHit | output | 1 | A window matched |
| rspDecErr | output | 1 | No window matched |
| rspWin | output | 3 | Index of the matching window |
| rspAddr | output | 40 | Translated downstream address |
| irq | output | 1 | Decode-error interrupt |

## Verification
The properties assume that the register port and the request port are driven from the same clock domain and are stable around the sampling edge. They also assume that software clears the status only through a write to offset 0xCC. Two register writes are never merged by the properties; each one is judged on its own edge. The stimulus changes every input half a period away from the active edge and holds it for a full cycle. It issues requests that hit, land exactly on window edges, overlap two windows, fall in a zero-length window, and collide with a register write. The bench keeps its own register image and derives each expected response from it. It never reads the design's internal state.

// File: rtl/obx_pkg.sv
package obx_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture a response for the request accepted this cycle
  } obxStrobe_t;

  localparam int REG_W       = 32;
  localparam int DEC_ERR_BIT = 6;
endpackage

// File: rtl/obx_ctrl.sv
module obx_ctrl
  import obx_pkg::*;
#(
  parameter int NUM_WIN    = 6,
  parameter int REG_AW     = 8,
  parameter int PG_W       = 28,
  parameter int INTEN_OFS  = 'hC8,
  parameter int STAT_OFS   = 'hCC
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           regWrEn,
  input  logic [REG_AW-1:0]              regAddr,
  input  logic [REG_W-1:0]               regWdata,
  output logic [REG_W-1:0]               regRdata,
  input  logic                           reqValid,
  output logic                           reqReady,
  input  logic                           missNow,
  output logic [NUM_WIN-1:0][REG_W-1:0]  winSize,
  output logic [NUM_WIN-1:0][REG_W-1:0]  winStart,
  output logic [NUM_WIN-1:0][PG_W-1:0]   winPage,
  output logic                           decSticky,
  output logic                           irq,
  output obxStrobe_t                     strobe
);
  localparam int SIZE_BASE  = 0;
  localparam int START_BASE = 4 * NUM_WIN;
  localparam int DSB_BASE   = 8 * NUM_WIN;

  logic [NUM_WIN-1:0][REG_W-1:0] winBase;
  logic [REG_W-1:0]              intEnReg;
  logic                          accept;
  logic                          clrHit;

  assign reqReady = !regWrEn;
  assign accept   = reqValid && reqReady;
  assign strobe.load = accept;

  assign clrHit = regWrEn && (regAddr == REG_AW'(STAT_OFS)) && regWdata[DEC_ERR_BIT];

  // Window register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winSize  <= '0;
      winStart <= '0;
      winBase  <= '0;
      intEnReg <= '0;
    end else if (regWrEn) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (regAddr == REG_AW'(SIZE_BASE + 4 * i))  winSize[i]  <= regWdata;
        if (regAddr == REG_AW'(START_BASE + 4 * i)) winStart[i] <= regWdata;
        if (regAddr == REG_AW'(DSB_BASE + 4 * i))   winBase[i]  <= regWdata;
      end
      if (regAddr == REG_AW'(INTEN_OFS)) intEnReg <= regWdata;
    end
  end

  // Sticky decode-error status; a new error wins over a clear
  always_ff @(posedge clk) begin
    if (!rst_n)                decSticky <= 1'b0;
    else if (accept && missNow) decSticky <= 1'b1;
    else if (clrHit)           decSticky <= 1'b0;
  end

  assign irq = decSticky && intEnReg[DEC_ERR_BIT];

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_page
      assign winPage[g] = winBase[g][4 +: PG_W];
    end
  endgenerate

  // Read mux
  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (regAddr == REG_AW'(SIZE_BASE + 4 * i))  regRdata = winSize[i];
      if (regAddr == REG_AW'(START_BASE + 4 * i)) regRdata = winStart[i];
      if (regAddr == REG_AW'(DSB_BASE + 4 * i))   regRdata = winBase[i];
    end
    if (regAddr == REG_AW'(INTEN_OFS)) regRdata = intEnReg;
    if (regAddr == REG_AW'(STAT_OFS))  regRdata[DEC_ERR_BIT] = decSticky;
  end
endmodule

// File: rtl/obx_dpath.sv
module obx_dpath
  import obx_pkg::*;
#(
  parameter int NUM_WIN    = 6,
  parameter int ADDR_W     = 32,
  parameter int DS_W       = 40,
  parameter int PAGE_SHIFT = 12,
  parameter int WIN_IDX_W  = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  obxStrobe_t                         strobe,
  input  logic [ADDR_W-1:0]                  reqAddr,
  input  logic [NUM_WIN-1:0][REG_W-1:0]      winSize,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]     winStart,
  input  logic [NUM_WIN-1:0][DS_W-PAGE_SHIFT-1:0] winPage,
  output logic                               missNow,
  output logic                               rspValid,
  output logic                               rspHit,
  output logic                               rspDecErr,
  output logic [WIN_IDX_W-1:0]               rspWin,
  output logic [DS_W-1:0]                    rspAddr
);
  localparam int LEN_W = REG_W + PAGE_SHIFT;
  localparam int OFF_W = (LEN_W > ADDR_W) ? LEN_W : ADDR_W;

  logic [NUM_WIN-1:0]                 inWin;
  logic [NUM_WIN-1:0][ADDR_W-1:0]     offs;
  logic [NUM_WIN-1:0][DS_W-1:0]       xAddr;
  logic                               hitAny;
  logic [WIN_IDX_W-1:0]               selWin;
  logic [DS_W-1:0]                    selAddr;

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
      logic             geStart;
      logic [OFF_W-1:0] winLen;
      logic [OFF_W-1:0] offWide;
      assign offs[g]   = reqAddr - winStart[g];
      assign geStart   = reqAddr >= winStart[g];
      assign winLen    = OFF_W'({winSize[g], {PAGE_SHIFT{1'b0}}});
      assign offWide   = OFF_W'(offs[g]);
      assign inWin[g]  = (winSize[g] != '0) && geStart && (offWide < winLen);
      assign xAddr[g]  = {winPage[g], {PAGE_SHIFT{1'b0}}} + DS_W'(offs[g]);
    end
  endgenerate

  // Lowest index has priority: scan downward so the last assignment wins
  always_comb begin
    hitAny  = 1'b0;
    selWin  = '0;
    selAddr = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (inWin[i]) begin
        hitAny  = 1'b1;
        selWin  = WIN_IDX_W'(i);
        selAddr = xAddr[i];
      end
    end
  end

  assign missNow = !hitAny;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspDecErr <= 1'b0;
      rspWin    <= '0;
      rspAddr   <= '0;
    end else if (strobe.load) begin
      rspValid  <= 1'b1;
      rspHit    <= hitAny;
      rspDecErr <= !hitAny;
      rspWin    <= selWin;
      rspAddr   <= selAddr;
    end else begin
      rspValid  <= 1'b0;
    end
  end
endmodule

// File: rtl/ob_window_xlate.sv
module ob_window_xlate
  import obx_pkg::*;
#(
  parameter int NUM_WIN    = 6,
  parameter int ADDR_W     = 32,
  parameter int DS_W       = 40,
  parameter int PAGE_SHIFT = 12,
  parameter int REG_AW     = 8,
  parameter int INTEN_OFS  = 'hC8,
  parameter int STAT_OFS   = 'hCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspDecErr,
  output logic [2:0]        rspWin,
  output logic [DS_W-1:0]   rspAddr,
  output logic              irq
);
  localparam int PG_W = DS_W - PAGE_SHIFT;

  obxStrobe_t                    strobe;
  logic                          missNow;
  logic                          decSticky;
  logic [NUM_WIN-1:0][31:0]      winSize;
  logic [NUM_WIN-1:0][31:0]      winStart;
  logic [NUM_WIN-1:0][PG_W-1:0]  winPage;

  obx_ctrl #(
    .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .PG_W(PG_W),
    .INTEN_OFS(INTEN_OFS), .STAT_OFS(STAT_OFS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .reqValid(reqValid), .reqReady(reqReady), .missNow(missNow),
    .winSize(winSize), .winStart(winStart), .winPage(winPage),
    .decSticky(decSticky), .irq(irq), .strobe(strobe)
  );

  obx_dpath #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DS_W(DS_W),
    .PAGE_SHIFT(PAGE_SHIFT), .WIN_IDX_W(3)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqAddr(reqAddr),
    .winSize(winSize), .winStart(winStart), .winPage(winPage),
    .missNow(missNow), .rspValid(rspValid), .rspHit(rspHit),
    .rspDecErr(rspDecErr), .rspWin(rspWin), .rspAddr(rspAddr)
  );
endmodule

// File: rtl/obx_checker.sv
module obx_checker #(
  parameter int REG_AW   = 8,
  parameter int DS_W     = 40,
  parameter int STAT_OFS = 'hCC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspHit,
  input logic              rspDecErr,
  input logic [DS_W-1:0]   rspAddr,
  input logic              decSticky
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> rspValid); // R6
  AST_NO_RSP_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && reqReady) |=> !rspValid); // R6
  AST_HIT_OR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> (rspHit != rspDecErr)); // R7
  AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspDecErr) |-> (rspAddr == '0)); // R7
  AST_ERR_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspDecErr) |-> decSticky); // R7
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (decSticky && !(regWrEn && regAddr == REG_AW'(STAT_OFS) && regWdata[6])) |=> decSticky); // R8
  AST_WRITE_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> !reqReady); // R10
endmodule

bind ob_window_xlate obx_checker #(
  .REG_AW(REG_AW), .DS_W(DS_W), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWdata(regWdata), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspHit(rspHit), .rspDecErr(rspDecErr),
  .rspAddr(rspAddr), .decSticky(decSticky)
);

// File: tb/test_ob_window_xlate.sv
module test_ob_window_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady, rspValid, rspHit, rspDecErr, irq;
  logic [2:0]  rspWin;
  logic [39:0] rspAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ob_window_xlate i_ob_window_xlate (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqReady(reqReady), .rspValid(rspValid),
    .rspHit(rspHit), .rspDecErr(rspDecErr), .rspWin(rspWin),
    .rspAddr(rspAddr), .irq(irq)
  );

  typedef struct {
    bit     hit;
    int     win;
    longint addr;
    string  req;
  } exp_t;

  exp_t   sbq[$];
  int     nChecks = 0;
  int     nFails  = 0;
  bit     done    = 0;
  longint mSize[6], mStart[6], mBase[6];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    for (int w = 0; w < 6; w++) begin
      if (a == 8'(4*w))      mSize[w]  = d;
      if (a == 8'(24 + 4*w)) mStart[w] = d;
      if (a == 8'(48 + 4*w)) mBase[w]  = d;
    end
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] e, input string req);
    regAddr = a;
    #1;
    chk(regRdata == e, req, $sformatf("read @0x%0h", a), regRdata, e);
  endtask

  function automatic exp_t predict(input longint a, input string req);
    exp_t r;
    r.hit = 0; r.win = 0; r.addr = 0; r.req = req;
    for (int w = 0; w < 6; w++) begin
      if (!r.hit && mSize[w] != 0 && a >= mStart[w] && (a - mStart[w]) < (mSize[w] << 12)) begin
        r.hit  = 1;
        r.win  = w;
        r.addr = (((mBase[w] >> 4) & 64'hFFFFFFF) << 12) + (a - mStart[w]);
      end
    end
    return r;
  endfunction

  // Driver: one request per call, expected item pushed to the scoreboard
  task automatic send(input logic [31:0] a, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    sbq.push_back(predict(longint'(a), req));
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && rspValid) begin
      if (sbq.size() == 0) begin
        chk(0, "R6", "response without request", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rspHit == e.hit, e.req, "hit", rspHit, e.hit);
        chk(rspDecErr == !e.hit, e.req, "decErr", rspDecErr, !e.hit);
        chk(rspWin == 3'(e.win), e.req, "window", rspWin, e.win);
        chk(rspAddr == 40'(e.addr), e.req, "address", rspAddr, e.addr);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    for (int w = 0; w < 6; w++) begin
      mSize[w] = 0; mStart[w] = 0; mBase[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rspValid == 0, "R1", "rspValid", rspValid, 0);
    chk(irq == 0, "R1", "irq", irq, 0);
    chk(reqReady == 1, "R1", "reqReady", reqReady, 1);
    rdChk(8'h00, 0, "R1"); rdChk(8'h18, 0, "R1"); rdChk(8'h44, 0, "R1");
    rdChk(8'hC8, 0, "R1"); rdChk(8'hCC, 0, "R1");

    // Program windows
    wr(8'h00, 32'h0000_1000); wr(8'h18, 32'h1000_0000); wr(8'h30, 32'h0123_4501);
    wr(8'h04, 32'h0000_0010); wr(8'h1C, 32'h2000_0000); wr(8'h34, 32'h0080_0001);
    wr(8'h08, 32'h0000_4000); wr(8'h20, 32'h4000_0000); wr(8'h38, 32'hFF00_0001);
    wr(8'h0C, 32'h0000_0100); wr(8'h24, 32'h4100_0000); wr(8'h3C, 32'h0100_0001);
    wr(8'h2C, 32'h8000_0000); wr(8'h44, 32'h0555_0001);   // window 5 length stays 0
    wr(8'h48, 32'hDEAD_BEEF); wr(8'h19, 32'h1234_5678);   // unmapped writes

    // R2 read-back and unmapped reads
    rdChk(8'h00, 32'h0000_1000, "R2");
    rdChk(8'h24, 32'h4100_0000, "R2");
    rdChk(8'h38, 32'hFF00_0001, "R2");
    rdChk(8'h44, 32'h0555_0001, "R2");
    rdChk(8'h48, 0, "R2");
    rdChk(8'h19, 0, "R2");
    rdChk(8'h18, 32'h1000_0000, "R2");
    rdChk(8'hFC, 0, "R2");

    // R3/R4 hits, edges
    send(32'h1000_0000, "R3");
    send(32'h10FF_FFFF, "R4");
    send(32'h2000_1234, "R4");
    send(32'h2000_FFFF, "R3");
    send(32'h4000_0040, "R4");
    // R5 overlap of windows 2 and 3
    send(32'h4100_0010, "R5");
    // R6 back-to-back requests
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h1000_0100;
    sbq.push_back(predict(64'h1000_0100, "R6"));
    @(negedge clk);
    reqAddr = 32'h2000_0008;
    sbq.push_back(predict(64'h2000_0008, "R6"));
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    rdChk(8'hCC, 0, "R7");

    // R3 zero-length window 5 and R7 miss
    send(32'h8000_0000, "R3");
    rdChk(8'hCC, 32'h0000_0040, "R7");
    chk(irq == 0, "R9", "irq with enable clear", irq, 0);
    send(32'h1100_0000, "R7");

    // R9 enable gating
    wr(8'hC8, 32'h0000_0040);
    chk(irq == 1, "R9", "irq enabled", irq, 1);
    rdChk(8'hC8, 32'h0000_0040, "R2");
    // R8 writing 0 does not clear
    wr(8'hCC, 32'hFFFF_FFBF);
    rdChk(8'hCC, 32'h0000_0040, "R8");
    chk(irq == 1, "R8", "irq after zero write", irq, 1);
    wr(8'hCC, 32'h0000_0040);
    rdChk(8'hCC, 0, "R8");
    chk(irq == 0, "R9", "irq after clear", irq, 0);

    // R10 request during register write is not accepted
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'hFC; regWdata = 32'h0;
    reqValid = 1'b1; reqAddr = 32'h9000_0000;
    #1;
    chk(reqReady == 0, "R10", "reqReady during write", reqReady, 0);
    @(negedge clk);
    regWrEn = 1'b0; reqValid = 1'b0;
    chk(rspValid == 0, "R10", "no response for blocked request", rspValid, 0);
    rdChk(8'hCC, 0, "R10");

    // R9 miss with interrupt enabled
    send(32'h0000_0010, "R7");
    chk(irq == 1, "R9", "irq after miss", irq, 1);

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R6", "responses outstanding", sbq.size(), 0);
    finishRun();
  end
endmodule